// File: doc/BRIEF.md
# Serial Dot-Product Engine

This block forms the inner product of two vectors of eight unsigned 16-bit elements. Each vector arrives as one 128-bit word. One multiplier and one adder work through the element pairs in index order, one pair per clock. Each pair's product is added into a 36-bit accumulator. After the eighth pair a completion flag rises, and from then on the accumulated value and the flag stay as they are.

A new computation starts only with a reset. The caller sets both operand words, holds reset low for at least one clock, and releases it. Eight clocks later the sum is ready on the output. It stays there until the next reset, so a slow consumer can take it whenever it likes. Reset is synchronous and active low.

Top module: `dotp_serial`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge sets `dot_out` to 0 and `dot_done` to 0.
- R2: Element i of each operand sits in bits [16*i+15 : 16*i] of its word, so element 0 occupies the least significant 16 bits. Elements are treated as unsigned.
- R3: After the k-th rising edge with `rst_n` high (k from 1 to 8), `dot_out` equals the sum over i from 0 to k-1 of a[i]*b[i]. Elements are therefore consumed in ascending index order, one pair per edge.
- R4: `dot_done` stays low after each of the first seven edges following reset release and is high after the eighth.
- R5: Once `dot_done` is high, `dot_out` and `dot_done` keep their values at every edge while `rst_n` stays high, even when the operand words change.
- R6: The 36-bit result holds the largest possible sum without overflow. With all elements at 0xFFFF it reads 0x7FFF00008.
- R7: Asserting `rst_n` low part-way through a computation discards the partial sum. A full computation then follows the next release of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| vec_a | input | 128 | First operand, eight packed 16-bit unsigned elements |
| vec_b | input | 128 | Second operand, eight packed 16-bit unsigned elements |
| dot_out | output | 36 | Accumulated inner product |
| dot_done | output | 1 | High once all eight products have been summed |

## Verification
Each partial sum is registered, so it is due exactly one rising edge after the previous one. The k-th partial is visible on the falling edge after the k-th rising edge that follows reset release. The bench drives inputs and compares outputs only on falling edges, and checks every one of the eight partials against a sum computed from the operand words. `dot_done` is checked low at edges one to seven and high at edge eight. Hold behaviour is checked over several further edges after the operands have been replaced. The operand sets include a sweep that puts a single nonzero pair at each element position in turn, incrementing and all-ones patterns, random words, and a reset applied part-way through a run.

// File: rtl/dotp_pkg.sv
// Package: shared sizing defaults and width helpers for the serial
// dot-product engine. Assumes element count of at least two.
package dotp_pkg;

    localparam int unsigned DEF_ELEM_W = 16;
    localparam int unsigned DEF_N_ELEM = 8;

    // Accumulator width: a full product plus growth bits for the sum,
    // with one spare bit of headroom.
    function automatic int unsigned acc_width(input int unsigned elem_w,
                                              input int unsigned n_elem);
        return 2 * elem_w + $clog2(n_elem) + 1;
    endfunction

endpackage

// File: rtl/dotp_elem_sel.sv
// Module: picks element `idx` from each packed operand word.
// Assumes element i occupies bits [ELEM_W*i +: ELEM_W]; purely combinational.
module dotp_elem_sel #(
    parameter int unsigned ELEM_W = 16,
    parameter int unsigned N_ELEM = 8,
    localparam int unsigned IDX_W  = $clog2(N_ELEM),
    localparam int unsigned VEC_W  = ELEM_W * N_ELEM
) (
    input  logic [VEC_W-1:0]  vec_a,
    input  logic [VEC_W-1:0]  vec_b,
    input  logic [IDX_W-1:0]  idx,
    output logic [ELEM_W-1:0] elem_a,
    output logic [ELEM_W-1:0] elem_b
);

    logic [ELEM_W-1:0] lane_a [N_ELEM];
    logic [ELEM_W-1:0] lane_b [N_ELEM];

    // Unpack both operand words into element lanes.
    for (genvar g = 0; g < N_ELEM; g++) begin : g_lane
        assign lane_a[g] = vec_a[g*ELEM_W +: ELEM_W];
        assign lane_b[g] = vec_b[g*ELEM_W +: ELEM_W];
    end

    // Select the lane addressed by the current index.
    always_comb begin
        elem_a = '0;
        elem_b = '0;
        for (int i = 0; i < N_ELEM; i++) begin
            if (idx == IDX_W'(i)) begin
                elem_a = lane_a[i];
                elem_b = lane_b[i];
            end
        end
    end

endmodule

// File: rtl/dotp_seq.sv
// Module: element index walker and sticky completion flag.
// Assumes synchronous active-low reset; index and flag freeze once done.
module dotp_seq #(
    parameter int unsigned N_ELEM = 8,
    localparam int unsigned IDX_W = $clog2(N_ELEM),
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ELEM - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] idx,
    output logic             done,
    output logic             step
);

    // A step happens on every edge until completion.
    assign step = ~done;

    // Advance the index and latch completion on the last element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            idx  <= (idx == LAST) ? '0 : idx + IDX_W'(1);
            done <= (idx == LAST);
        end
    end

    // R3: index advances by one per active edge before the last element
    a_r3_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && idx != LAST) |=> (idx == $past(idx) + IDX_W'(1)));

    // R4: completion rises only after the last element was processed
    a_r4_done_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(idx) == LAST));

    // R5: completion flag is sticky until reset
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

endmodule

// File: rtl/dotp_mac.sv
// Module: unsigned multiply-accumulate register.
// Assumes operands unsigned; accumulates only when `step` is high.
module dotp_mac #(
    parameter int unsigned ELEM_W = 16,
    parameter int unsigned ACC_W  = 36,
    localparam int unsigned PROD_W = 2 * ELEM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [ELEM_W-1:0] opnd_a,
    input  logic [ELEM_W-1:0] opnd_b,
    output logic [ACC_W-1:0]  acc
);

    logic [PROD_W-1:0] prod;

    // Full-width unsigned product of the current element pair.
    assign prod = opnd_a * opnd_b;

    // Add the product into the accumulator while stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (step) begin
            acc <= acc + ACC_W'(prod);
        end
    end

    // R5: accumulator holds when no step is taken
    a_r5_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(acc));

    // R6: accumulation never wraps
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (acc >= $past(acc)));

endmodule

// File: rtl/dotp_serial.sv
// Module: top of the serial dot-product engine. Walks element pairs in
// ascending order, one multiply-accumulate per clock, then freezes.
// Assumes operands stay stable during a computation; restart needs reset.
module dotp_serial
    import dotp_pkg::*;
#(
    parameter int unsigned ELEM_W = DEF_ELEM_W,
    parameter int unsigned N_ELEM = DEF_N_ELEM,
    localparam int unsigned IDX_W = $clog2(N_ELEM),
    localparam int unsigned VEC_W = ELEM_W * N_ELEM,
    localparam int unsigned ACC_W = acc_width(ELEM_W, N_ELEM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] vec_a,
    input  logic [VEC_W-1:0] vec_b,
    output logic [ACC_W-1:0] dot_out,
    output logic             dot_done
);

    logic [IDX_W-1:0]  idx;
    logic              step;
    logic [ELEM_W-1:0] elem_a;
    logic [ELEM_W-1:0] elem_b;

    dotp_seq #(.N_ELEM(N_ELEM)) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .idx  (idx),
        .done (dot_done),
        .step (step)
    );

    dotp_elem_sel #(.ELEM_W(ELEM_W), .N_ELEM(N_ELEM)) u_sel (
        .vec_a (vec_a),
        .vec_b (vec_b),
        .idx   (idx),
        .elem_a(elem_a),
        .elem_b(elem_b)
    );

    dotp_mac #(.ELEM_W(ELEM_W), .ACC_W(ACC_W)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .opnd_a(elem_a),
        .opnd_b(elem_b),
        .acc   (dot_out)
    );

    // R1: a reset edge leaves result and flag cleared
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (dot_out == '0 && !dot_done));

endmodule

// File: tb/tb_dotp_serial.sv
module tb_dotp_serial;

    localparam int EW = 16;
    localparam int NE = 8;
    localparam int VW = EW * NE;
    localparam int AW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] vec_a = '0;
    logic [VW-1:0] vec_b = '0;
    logic [AW-1:0] dot_out;
    logic          dot_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dotp_serial dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .vec_a   (vec_a),
        .vec_b   (vec_b),
        .dot_out (dot_out),
        .dot_done(dot_done)
    );

    // Reference partial sum of the first k element products (R2 layout).
    function automatic logic [AW-1:0] ref_sum(input logic [VW-1:0] a,
                                              input logic [VW-1:0] b,
                                              input int k);
        logic [AW-1:0] s = '0;
        for (int i = 0; i < k; i++)
            s += AW'(a[i*EW +: EW]) * AW'(b[i*EW +: EW]);
        return s;
    endfunction

    task automatic chk(input string req, input logic [AW-1:0] got,
                       input logic [AW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Reset with given operands, then step through all eight elements.
    task automatic run_vec(input logic [VW-1:0] a, input logic [VW-1:0] b);
        @(negedge clk);
        rst_n = 1'b0;
        vec_a = a;
        vec_b = b;
        @(posedge clk);
        @(negedge clk);
        chk("R1 result", dot_out, '0);
        chk("R1 done", AW'(dot_done), '0);
        rst_n = 1'b1;
        for (int k = 1; k <= NE; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R3 partial", dot_out, ref_sum(a, b, k));
            chk("R4 done", AW'(dot_done), AW'(k == NE));
        end
    endtask

    // After completion, change operands and confirm nothing moves.
    task automatic hold_check(input logic [AW-1:0] exp);
        vec_a = {$urandom, $urandom, $urandom, $urandom};
        vec_b = {$urandom, $urandom, $urandom, $urandom};
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R5 hold result", dot_out, exp);
            chk("R5 hold done", AW'(dot_done), AW'(1));
        end
    endtask

    initial begin : watchdog
        #4_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin : main
        logic [VW-1:0] a, b;
        // R2: one nonzero pair per position, several values each
        for (int p = 0; p < NE; p++) begin
            for (int v = 0; v < 4; v++) begin
                a = '0;
                b = '0;
                a[p*EW +: EW] = EW'(16'h0101 * (v + 1) + p);
                b[p*EW +: EW] = EW'(16'h0033 + v * 16'h1111);
                run_vec(a, b);
                chk("R2 lane position", dot_out,
                    AW'(a[p*EW +: EW]) * AW'(b[p*EW +: EW]));
            end
        end
        // Incrementing pattern
        for (int i = 0; i < NE; i++) begin
            a[i*EW +: EW] = EW'(i + 1);
            b[i*EW +: EW] = EW'(i + 2);
        end
        run_vec(a, b);
        chk("R3 incrementing", dot_out, AW'(240));
        hold_check(AW'(240));
        // R6: all-ones operands, largest sum
        run_vec({VW{1'b1}}, {VW{1'b1}});
        chk("R6 max sum", dot_out, 36'h7FFF00008);
        hold_check(36'h7FFF00008);
        // Random words
        for (int t = 0; t < 40; t++) begin
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            run_vec(a, b);
            if (t % 8 == 0) hold_check(ref_sum(a, b, NE));
        end
        // R7: reset part-way through a run
        a = {$urandom, $urandom, $urandom, $urandom};
        b = {$urandom, $urandom, $urandom, $urandom};
        @(negedge clk);
        rst_n = 1'b0;
        vec_a = a;
        vec_b = b;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) @(posedge clk);
        @(negedge clk);
        chk("R7 partial before abort", dot_out, ref_sum(a, b, 3));
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R7 abort clears", dot_out, '0);
        chk("R7 abort done low", AW'(dot_done), '0);
        rst_n = 1'b1;
        for (int k = 1; k <= NE; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R7 rerun partial", dot_out, ref_sum(a, b, k));
        end
        chk("R7 rerun done", AW'(dot_done), AW'(1));
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule